// File: doc/BRIEF.md
# ARINC 429 Word Receiver with Inter-Word Gap Qualification

This block takes the digital output of an external line comparator and turns it into received 32-bit ARINC 429 words. The comparator reports the line as two level flags, one raised for the positive "one" level and one raised for the negative "zero" level. Both low means the line is at null. Both high is not a legal level and counts as neither. The receiver samples the flags on a sample tick, which comes every clock in fast mode and every eighth clock in slow mode. It keeps a short history of each of the three line conditions. A bit is taken when a level has been seen for three samples in a row and the line then returns to null.

The spacing between accepted bits is measured in sample ticks. If one spacing is shorter than the allowed minimum, the word is marked bad. If the spacing grows past the maximum, the partial word is abandoned. After the 32nd bit, a gap timer checks that the line stays at null before the word is handed over. It checks every 10 clocks in fast mode and every 80 clocks in slow mode. A qualified word goes into a holding buffer and raises a ready flag. The host reads the buffer as two 16-bit halves: it picks a half with a select input and strobes an enable.

Top module: `arx_receiver`

## Requirements
- R1: A synchronous active-high reset drives rxReady low, clears the three sample histories, the pending bit and the bit count, so a word that was in progress before the reset is dropped.
- R2: The line is classed as a one when only lineHi is high, as a zero when only lineLo is high, and as null when both are low. Both high is none of the three. The line is sampled every clock when slowMode is 0 and every 8 clocks when slowMode is 1.
- R3: A bit is accepted only after its level has been sampled on 3 consecutive ticks and a null sample follows. A level pulse of 2 samples or fewer never produces a bit.
- R4: Bits are shifted in least significant bit first, so the first bit received ends up in bit 0 of the word.
- R5: If any two consecutive accepted bits of a word are fewer than 8 sample ticks apart, the word is discarded and rxReady does not rise for it.
- R6: If more than 12 sample ticks pass after an accepted bit without the next one, the partial word is abandoned. The next accepted bit then becomes bit 0 of a new word.
- R7: After the 32nd bit, the gap timer samples the null history every 10 clocks (fast) or every 80 clocks (slow). The word is accepted after 2 consecutive samples in which all three recent line samples were null. Any sample that is not all null discards the word.
- R8: With readEn high, hostData shows bits 15:0 of the buffer when halfSel is 0 and bits 31:16 when halfSel is 1. With readEn low, hostData is 0.
- R9: rxReady stays high until both halves have been read while it is high, in either order and in separate cycles. It falls on the clock edge of the second of those reads. A read of only one half leaves it high.
- R10: A newly accepted word overwrites the buffer even if it was not read. If the acceptance falls in the same cycle as the completing read, rxReady stays high, the record of reads is cleared, and the new word is the one reported.
- R11: In slow mode, a word sent with the same tick-based timing as in fast mode is accepted intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| lineHi | input | 1 | Comparator flag: line at the one level |
| lineLo | input | 1 | Comparator flag: line at the zero level |
| slowMode | input | 1 | 1 selects the slow sample and gap intervals |
| halfSel | input | 1 | Half select for the host read: 0 lower, 1 upper |
| readEn | input | 1 | Host read strobe, one cycle per half |
| rxReady | output | 1 | A qualified word is waiting to be read |
| hostData | output | 16 | Selected half of the received word, 0 when not reading |

## Verification
Word acceptance at the end of the gap check and the host's completing read can land on the same clock edge. When they do, the reload must win and leave rxReady high for the fresh word. The bench provokes this as follows. It reads the low half of a held word. It then lets a second word arrive, and it times the upper-half read from its own reference model's prediction of the acceptance edge. It then judges three things: hostData still shows the old upper half in that cycle, rxReady stays high, and two more reads are needed to clear the new word.

// File: rtl/arx_pkg.sv
`timescale 1ns/1ps
package arx_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleEn;  // sample tick: shift the line histories
    logic shiftEn;   // accept one bit into the word register
    logic bitVal;    // value of the accepted bit
    logic loadBuf;   // copy the word into the host buffer
  } arxStrobe_t;

  // Line status from datapath to control
  typedef struct packed {
    logic lvlOne;    // one level held for the whole history
    logic lvlZero;   // zero level held for the whole history
    logic nullLast;  // most recent sample was null
    logic nullFull;  // whole history is null
  } arxStatus_t;

  typedef enum logic {ST_COLLECT, ST_GAP} arxState_t;

endpackage

// File: rtl/arx_datapath.sv
`timescale 1ns/1ps
module arx_datapath
  import arx_pkg::*;
#(
  parameter int WORD_BITS    = 32,
  parameter int HOLD_SAMPLES = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lineHi,
  input  logic                   lineLo,
  input  arxStrobe_t             ctl,
  input  logic                   halfSel,
  input  logic                   readEn,
  output arxStatus_t             stat,
  output logic [WORD_BITS/2-1:0] hostData
);

  localparam int HALF = WORD_BITS / 2;
  localparam int NUM_CLS = 3;  // 0: one, 1: zero, 2: null

  logic [NUM_CLS-1:0]   lineCls;
  logic [WORD_BITS-1:0] shiftWord;
  logic [WORD_BITS-1:0] bufWord;

  assign lineCls = {~lineHi & ~lineLo, lineLo & ~lineHi, lineHi & ~lineLo};

  // One sample history per line condition
  for (genvar g = 0; g < NUM_CLS; g++) begin : g_hist
    logic [HOLD_SAMPLES-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst)               sr <= '0;
      else if (ctl.sampleEn) sr <= {sr[HOLD_SAMPLES-2:0], lineCls[g]};
    end
  end

  assign stat.lvlOne   = &g_hist[0].sr;
  assign stat.lvlZero  = &g_hist[1].sr;
  assign stat.nullLast = g_hist[2].sr[0];
  assign stat.nullFull = &g_hist[2].sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftWord <= '0;
      bufWord   <= '0;
    end else begin
      if (ctl.shiftEn) shiftWord <= {ctl.bitVal, shiftWord[WORD_BITS-1:1]};
      if (ctl.loadBuf) bufWord   <= shiftWord;
    end
  end

  always_comb begin
    if (!readEn)     hostData = '0;
    else if (halfSel) hostData = bufWord[WORD_BITS-1 -: HALF];
    else              hostData = bufWord[HALF-1:0];
  end

endmodule

// File: rtl/arx_control.sv
`timescale 1ns/1ps
module arx_control
  import arx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int SAMP_HS   = 1,
  parameter int SAMP_LS   = 8,
  parameter int PER_MIN   = 8,
  parameter int PER_MAX   = 12,
  parameter int GAP_HS    = 10,
  parameter int GAP_LS    = 80,
  parameter int GAP_NEED  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slowMode,
  input  logic       halfSel,
  input  logic       readEn,
  input  arxStatus_t stat,
  output arxStrobe_t ctl,
  output logic       rxReady
);

  localparam int DIV_W = $clog2(SAMP_LS + 1);
  localparam int PER_W = $clog2(PER_MAX + 2);
  localparam int GAP_W = $clog2(GAP_LS + 1);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam int HIT_W = $clog2(GAP_NEED + 1);
  localparam logic [PER_W-1:0] PER_SAT   = PER_W'(PER_MAX + 1);
  localparam logic [PER_W:0]   PER_MIN_V = (PER_W+1)'(PER_MIN);
  localparam logic [PER_W:0]   PER_MAX_V = (PER_W+1)'(PER_MAX);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(WORD_BITS - 1);
  localparam logic [HIT_W-1:0] LAST_HIT  = HIT_W'(GAP_NEED - 1);

  arxState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [PER_W-1:0] periodCnt;
  logic [PER_W:0]   elapsed;
  logic [CNT_W-1:0] bitCnt;
  logic [GAP_W-1:0] gapTmr;
  logic [HIT_W-1:0] gapHits;
  logic pending, pendVal, badRate, readLo, readHi;
  logic tick, bitSeen, tooSlow, gapDue, lastHit, acceptNow, rdLoNow, rdHiNow;
  logic [DIV_W-1:0] tickLast;
  logic [GAP_W-1:0] gapLast;

  assign tickLast  = slowMode ? DIV_W'(SAMP_LS - 1) : DIV_W'(SAMP_HS - 1);
  assign gapLast   = slowMode ? GAP_W'(GAP_LS - 1) : GAP_W'(GAP_HS - 1);
  assign tick      = (divCnt == '0);
  assign elapsed   = {1'b0, periodCnt} + 1'b1;
  assign bitSeen   = tick & pending & stat.nullLast;
  assign tooSlow   = (bitCnt != '0) && (elapsed > PER_MAX_V);
  assign gapDue    = (state == ST_GAP) && (gapTmr == gapLast);
  assign lastHit   = (gapHits == LAST_HIT);
  assign acceptNow = gapDue & stat.nullFull & lastHit & ~badRate;
  assign rdLoNow   = readEn & ~halfSel;
  assign rdHiNow   = readEn & halfSel;

  assign ctl.sampleEn = tick;
  assign ctl.shiftEn  = (state == ST_COLLECT) & bitSeen;
  assign ctl.bitVal   = pendVal;
  assign ctl.loadBuf  = acceptNow;
  assign rxReady      = readyQ;

  logic readyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_COLLECT;
      divCnt    <= '0;
      periodCnt <= '0;
      bitCnt    <= '0;
      gapTmr    <= '0;
      gapHits   <= '0;
      pending   <= 1'b0;
      pendVal   <= 1'b0;
      badRate   <= 1'b0;
    end else begin
      divCnt <= (divCnt >= tickLast) ? '0 : divCnt + 1'b1;

      if (tick) begin
        if (bitSeen)           pending <= 1'b0;
        else if (stat.lvlOne)  {pending, pendVal} <= 2'b11;
        else if (stat.lvlZero) {pending, pendVal} <= 2'b10;
        if (bitSeen)                periodCnt <= '0;
        else if (periodCnt != PER_SAT) periodCnt <= periodCnt + 1'b1;
      end

      case (state)
        ST_COLLECT: if (tick) begin
          if (bitSeen) begin
            if (bitCnt == '0 || tooSlow) begin
              bitCnt  <= CNT_W'(1);
              badRate <= 1'b0;
            end else begin
              badRate <= badRate | (elapsed < PER_MIN_V);
              if (bitCnt == LAST_BIT) begin
                state   <= ST_GAP;
                bitCnt  <= '0;
                gapTmr  <= '0;
                gapHits <= '0;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else if (tooSlow) begin
            bitCnt  <= '0;
            badRate <= 1'b0;
          end
        end
        ST_GAP: begin
          if (gapDue) begin
            gapTmr <= '0;
            if (stat.nullFull && !lastHit) gapHits <= gapHits + 1'b1;
            else                           state   <= ST_COLLECT;
          end else begin
            gapTmr <= gapTmr + 1'b1;
          end
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  // Host handshake: load wins over the completing read
  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ <= 1'b0;
      readLo <= 1'b0;
      readHi <= 1'b0;
    end else if (acceptNow) begin
      readyQ <= 1'b1;
      readLo <= 1'b0;
      readHi <= 1'b0;
    end else if (readyQ) begin
      if ((readLo | rdLoNow) & (readHi | rdHiNow)) begin
        readyQ <= 1'b0;
        readLo <= 1'b0;
        readHi <= 1'b0;
      end else begin
        readLo <= readLo | rdLoNow;
        readHi <= readHi | rdHiNow;
      end
    end
  end

endmodule

// File: rtl/arx_receiver.sv
`timescale 1ns/1ps
module arx_receiver
  import arx_pkg::*;
#(
  parameter int WORD_BITS    = 32,
  parameter int HOLD_SAMPLES = 3,
  parameter int SAMP_HS      = 1,
  parameter int SAMP_LS      = 8,
  parameter int PER_MIN      = 8,
  parameter int PER_MAX      = 12,
  parameter int GAP_HS       = 10,
  parameter int GAP_LS       = 80,
  parameter int GAP_NEED     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lineHi,
  input  logic                   lineLo,
  input  logic                   slowMode,
  input  logic                   halfSel,
  input  logic                   readEn,
  output logic                   rxReady,
  output logic [WORD_BITS/2-1:0] hostData
);

  arxStrobe_t ctl;
  arxStatus_t stat;

  arx_control #(
    .WORD_BITS(WORD_BITS), .SAMP_HS(SAMP_HS), .SAMP_LS(SAMP_LS),
    .PER_MIN(PER_MIN), .PER_MAX(PER_MAX), .GAP_HS(GAP_HS),
    .GAP_LS(GAP_LS), .GAP_NEED(GAP_NEED)
  ) u_ctrl (
    .clk(clk), .rst(rst), .slowMode(slowMode), .halfSel(halfSel),
    .readEn(readEn), .stat(stat), .ctl(ctl), .rxReady(rxReady)
  );

  arx_datapath #(
    .WORD_BITS(WORD_BITS), .HOLD_SAMPLES(HOLD_SAMPLES)
  ) u_dp (
    .clk(clk), .rst(rst), .lineHi(lineHi), .lineLo(lineLo), .ctl(ctl),
    .halfSel(halfSel), .readEn(readEn), .stat(stat), .hostData(hostData)
  );

endmodule

// File: rtl/arx_checker.sv
`timescale 1ns/1ps
module arx_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rxReady,
  input logic              readEn,
  input logic [DATA_W-1:0] hostData,
  input logic              loadPulse,
  input logic              shiftPulse,
  input logic              nullLast
);

  AST_RESET_CLEARS_READY: assert property (@(posedge clk) rst |=> !rxReady); // R1

  AST_BIT_AFTER_NULL: assert property (@(posedge clk) disable iff (rst)
    shiftPulse |-> nullLast); // R3

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !readEn |-> (hostData == '0)); // R8

  AST_READY_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    (rxReady && !readEn) |=> rxReady); // R9

  AST_LOAD_SETS_READY: assert property (@(posedge clk) disable iff (rst)
    loadPulse |=> rxReady); // R10

endmodule

bind arx_receiver arx_checker #(.DATA_W(WORD_BITS/2)) u_chk (
  .clk(clk), .rst(rst), .rxReady(rxReady), .readEn(readEn),
  .hostData(hostData), .loadPulse(ctl.loadBuf), .shiftPulse(ctl.shiftEn),
  .nullLast(stat.nullLast)
);

// File: tb/arx_receiver_test.sv
`timescale 1ns/1ps
module arx_receiver_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineHi = 1'b0, lineLo = 1'b0, slowMode = 1'b0, halfSel = 1'b0, readEn = 1'b0;
  logic        rxReady;
  logic [15:0] hostData;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  arx_receiver uut (
    .clk(clk), .rst(rst), .lineHi(lineHi), .lineLo(lineLo), .slowMode(slowMode),
    .halfSel(halfSel), .readEn(readEn), .rxReady(rxReady), .hostData(hostData)
  );

  always #10 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int mDiv, h0, h1, h2, mPend, mPval, mPer, mCnt, mBad, mGap, mGt, mGh, mRdy, mRl, mRh;
  logic [31:0] mWord, mBuf;
  bit mAccNext;

  function automatic int lineCode(logic hi, logic lo);
    if (hi && !lo) return 1;
    if (lo && !hi) return 2;
    if (!hi && !lo) return 0;
    return 3;
  endfunction

  always @(posedge clk) begin
    int per, gl, el;
    bit tk, seen, nf, acc, rlo, rhi;
    if (rst) begin
      mDiv = 0; h0 = 3; h1 = 3; h2 = 3; mPend = 0; mPval = 0; mPer = 0;
      mCnt = 0; mBad = 0; mGap = 0; mGt = 0; mGh = 0; mRdy = 0; mRl = 0; mRh = 0;
      mWord = '0; mBuf = '0; mAccNext = 0;
    end else begin
      per = slowMode ? 8 : 1;
      gl  = slowMode ? 80 : 10;
      tk  = (mDiv == 0);
      mDiv = (mDiv >= per - 1) ? 0 : mDiv + 1;
      nf   = (h0 == 0 && h1 == 0 && h2 == 0);
      seen = tk && (mPend != 0) && (h0 == 0);
      el   = mPer + 1;
      acc  = 0;
      if (mGap != 0) begin
        if (mGt == gl - 1) begin
          mGt = 0;
          if (nf && mGh == 1) begin acc = (mBad == 0); mGap = 0; end
          else if (nf) mGh = mGh + 1;
          else mGap = 0;
        end else mGt = mGt + 1;
      end else if (tk) begin
        if (seen) begin
          mWord = {mPval[0], mWord[31:1]};
          if (mCnt == 0 || el > 12) begin mCnt = 1; mBad = 0; end
          else begin
            if (el < 8) mBad = 1;
            if (mCnt == 31) begin mGap = 1; mCnt = 0; mGt = 0; mGh = 0; end
            else mCnt = mCnt + 1;
          end
        end else if (mCnt != 0 && el > 12) begin mCnt = 0; mBad = 0; end
      end
      if (tk) begin
        if (seen) mPend = 0;
        else if (h0 == 1 && h1 == 1 && h2 == 1) begin mPend = 1; mPval = 1; end
        else if (h0 == 2 && h1 == 2 && h2 == 2) begin mPend = 1; mPval = 0; end
        mPer = seen ? 0 : ((mPer < 13) ? mPer + 1 : 13);
        h2 = h1; h1 = h0; h0 = lineCode(lineHi, lineLo);
      end
      if (acc) begin mBuf = mWord; mRdy = 1; mRl = 0; mRh = 0; end
      else if (mRdy != 0) begin
        rlo = readEn && !halfSel;
        rhi = readEn && halfSel;
        if ((mRl != 0 || rlo) && (mRh != 0 || rhi)) begin mRdy = 0; mRl = 0; mRh = 0; end
        else begin if (rlo) mRl = 1; if (rhi) mRh = 1; end
      end
      mAccNext = (mGap != 0) && (mGt == gl - 1) && (mGh == 1) &&
                 (h0 == 0 && h1 == 0 && h2 == 0) && (mBad == 0);
    end
  end

  // Per-clock comparison, away from the edge
  always begin
    logic [15:0] expData;
    @(posedge clk);
    #15;
    expData = !readEn ? 16'h0 : (halfSel ? mBuf[31:16] : mBuf[15:0]);
    tests++;
    if (rxReady !== mRdy[0]) begin
      fails++;
      $display("FAIL R9 model rxReady: actual %0b expected %0b at cycle %0d", rxReady, mRdy[0], cycles);
    end
    tests++;
    if (hostData !== expData) begin
      fails++;
      $display("FAIL R8 model hostData: actual %h expected %h at cycle %0d", hostData, expData, cycles);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R7 watchdog expired: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic setLine(int c);
    lineHi = (c == 1 || c == 3);
    lineLo = (c == 2 || c == 3);
  endtask

  function automatic int tclk();
    return slowMode ? 8 : 1;
  endfunction

  task automatic idle(int ticks);
    setLine(0);
    cyc(ticks * tclk());
  endtask

  // level for hi ticks, then null for nu ticks; glitch>0 puts a 2-tick pulse of that code into the null
  task automatic sendBit(bit v, int hi, int nu, int glitch);
    setLine(v ? 1 : 2);
    cyc(hi * tclk());
    setLine(0);
    if (glitch > 0) begin
      cyc(2 * tclk());
      setLine(glitch);
      cyc(2 * tclk());
      setLine(0);
      cyc((nu - 4) * tclk());
    end else begin
      cyc(nu * tclk());
    end
  endtask

  task automatic sendWord(logic [31:0] w, int hi, int nu);
    for (int i = 0; i < 32; i++) sendBit(w[i], hi, nu, 0);
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readHalf(bit sel, output logic [15:0] v);
    halfSel = sel;
    readEn  = 1'b1;
    #10;
    v = hostData;
    @(posedge clk); #5;
    readEn  = 1'b0;
  endtask

  task automatic expectWord(logic [31:0] w, string tag);
    logic [15:0] lo, hi;
    check(rxReady === 1'b1, {tag, " ready"}, {31'b0, rxReady}, 32'h1);
    readHalf(1'b0, lo);
    check(lo === w[15:0], {tag, " low half"}, {16'h0, lo}, {16'h0, w[15:0]});
    readHalf(1'b1, hi);
    check(hi === w[31:16], {tag, " high half"}, {16'h0, hi}, {16'h0, w[31:16]});
    check(rxReady === 1'b0, {tag, " cleared"}, {31'b0, rxReady}, 32'h0);
  endtask

  // ---------------- test sequence ----------------
  initial begin
    logic [15:0] v;
    int guard;

    // R1: reset state
    readEn = 1'b1; halfSel = 1'b1;
    cyc(3);
    check(rxReady === 1'b0, "R1 reset rxReady", {31'b0, rxReady}, 32'h0);
    #10;
    check(hostData === 16'h0, "R1 reset hostData", {16'h0, hostData}, 32'h0);
    cyc(1);
    rst = 1'b0; readEn = 1'b0;
    idle(20);

    // R4: first bit lands in bit 0; R9: one half leaves ready high
    sendWord(32'h0000_0001, 5, 5);
    idle(40);
    check(rxReady === 1'b1, "R7 accepted after gap", {31'b0, rxReady}, 32'h1);
    readHalf(1'b0, v);
    check(v === 16'h0001, "R4 lsb first", {16'h0, v}, 32'h1);
    check(rxReady === 1'b1, "R9 one half read", {31'b0, rxReady}, 32'h1);
    #10;
    check(hostData === 16'h0, "R8 bus idle", {16'h0, hostData}, 32'h0);
    cyc(1);
    readHalf(1'b1, v);
    check(v === 16'h0000, "R4 upper half", {16'h0, v}, 32'h0);
    check(rxReady === 1'b0, "R9 both halves read", {31'b0, rxReady}, 32'h0);

    // R8/R9: upper half read first
    sendWord(32'hA5C3_1F08, 5, 5);
    idle(40);
    readHalf(1'b1, v);
    check(v === 16'hA5C3, "R8 upper select", {16'h0, v}, 32'hA5C3);
    readHalf(1'b0, v);
    check(v === 16'h1F08, "R8 lower select", {16'h0, v}, 32'h1F08);
    check(rxReady === 1'b0, "R9 reverse order clear", {31'b0, rxReady}, 32'h0);

    // R5: bit period 6 ticks is too fast
    sendWord(32'h1357_9BDF, 3, 3);
    idle(40);
    check(rxReady === 1'b0, "R5 too fast discarded", {31'b0, rxReady}, 32'h0);

    // R6: partial word abandoned after a long null
    for (int i = 0; i < 5; i++) sendBit(1'b1, 5, 5, 0);
    idle(10);
    sendWord(32'h3C3C_5AA5, 5, 5);
    idle(40);
    expectWord(32'h3C3C_5AA5, "R6 restart after stall");

    // R7: no null gap after the word
    sendWord(32'h1234_5678, 5, 5);
    for (int i = 0; i < 8; i++) sendBit(i[0], 5, 5, 0);
    idle(40);
    check(rxReady === 1'b0, "R7 missing gap discarded", {31'b0, rxReady}, 32'h0);

    // R3/R2: short pulses and both-high inside the null phase
    for (int i = 0; i < 32; i++) begin
      logic [31:0] w;
      w = 32'h0F0F_F0F0;
      sendBit(w[i], 5, 5, i[0] ? 3 : (w[i] ? 2 : 1));
    end
    idle(40);
    expectWord(32'h0F0F_F0F0, "R3 short pulses ignored");

    // R10: overwrite without read
    sendWord(32'h1111_2222, 5, 5);
    idle(40);
    sendWord(32'h3333_4444, 5, 5);
    idle(40);
    expectWord(32'h3333_4444, "R10 overwrite");

    // R10: acceptance coincides with the completing read
    sendWord(32'h5555_6666, 5, 5);
    idle(40);
    readHalf(1'b0, v);
    check(v === 16'h6666, "R10 first word low", {16'h0, v}, 32'h6666);
    sendWord(32'h7777_8888, 5, 5);
    setLine(0);
    guard = 0;
    while (!mAccNext && guard < 200) begin cyc(1); guard++; end
    readHalf(1'b1, v);
    check(v === 16'h5555, "R10 old data in collision cycle", {16'h0, v}, 32'h5555);
    check(rxReady === 1'b1, "R10 load wins collision", {31'b0, rxReady}, 32'h1);
    readHalf(1'b1, v);
    check(v === 16'h7777, "R10 new word high", {16'h0, v}, 32'h7777);
    check(rxReady === 1'b1, "R10 read record cleared", {31'b0, rxReady}, 32'h1);
    readHalf(1'b0, v);
    check(v === 16'h8888, "R10 new word low", {16'h0, v}, 32'h8888);
    check(rxReady === 1'b0, "R9 clear after new word", {31'b0, rxReady}, 32'h0);

    // R11: slow mode
    slowMode = 1'b1;
    idle(20);
    sendWord(32'h9ABC_DEF0, 5, 5);
    idle(40);
    expectWord(32'h9ABC_DEF0, "R11 slow mode word");
    slowMode = 1'b0;
    idle(20);

    // R1: reset in the middle of a word
    for (int i = 0; i < 16; i++) sendBit(i[1], 5, 5, 0);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    sendWord(32'hCAFE_0123, 5, 5);
    idle(40);
    expectWord(32'hCAFE_0123, "R1 reset drops partial word");

    idle(10);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule